// File: doc/BRIEF.md
# Transceiver Low-Power Mode Controller

This block holds the operating mode of a fault-tolerant bus transceiver. Two control pins, a standby select and an enable, choose between normal operation, a power-on standby used to read back a power-on indication, a goto-sleep request, and a low-power state. That low-power state is sleep if a goto-sleep request was accepted earlier and standby if not. The block drives the inhibit output that switches the external supply regulator. It also decides what the receive-data and error pins show in each mode.

A goto-sleep request releases the inhibit output only after it has been held for a programmable number of ticks. Two sticky flags record events that software must see. The wake-up flag is set by a qualified local or remote wake. The power-on flag is set by reset or a battery power-on pulse. Only normal mode clears the two flags. The local wake pin is filtered for an edge followed by a stable level. Each bus wire's dominant indication is filtered for a minimum dominant time. Both wake sources are listened to only outside normal mode. Supply undervoltage forces both control inputs low.

Top module: `lpm_ctrl`

## Requirements
- R1: The control pins are sampled into a register each clock. `mode_o` decodes the sampled pair {stb_pin, en_pin} as follows:
  - 11 gives normal = 4.
  - 10 gives power-on standby = 3.
  - 01 gives goto-sleep = 2.
  - 00 gives sleep = 0 if a goto-sleep was accepted, otherwise standby = 1.
- R2: A goto-sleep request is accepted only after the sampled pair has read 01 for SLEEP_TICKS consecutive clocks. `inh_o` falls at the (SLEEP_TICKS+1)-th rising edge after 01 is first presented. A shorter request leaves `inh_o` high and the 00 state in standby.
- R3: `inh_o` falls only on an accepted goto-sleep. Sleep mode is never shown while `inh_o` is high. Any event that re-asserts `inh_o` turns a later 00 into standby.
- R4: Reset and a `bat_por` pulse both set the power-on flag and drive `inh_o` high. Out of reset, `mode_o` is standby and `inh_o`, `rxd_o` and `err_o` all read 1.
- R5: The pins show different values per mode (0 means active):
  - In normal mode, `rxd_o` follows `rx_bit` and `err_o` is the inverse of `wire_fault`.
  - In power-on standby, `err_o` is the inverted power-on flag and `rxd_o` is the inverted wake-up flag.
  - In standby, sleep and goto-sleep, both pins show the inverted wake-up flag.
- R6: While the sampled pair is 11, both sticky flags are cleared, and the clear wins over any set.
- R7: A local wake needs two things on `wake_pin`: an edge of either polarity, then the new level held for WAKE_TICKS clocks. It sets the wake-up flag and `inh_o` at the (WAKE_TICKS+1)-th rising edge after the edge. The wake pin is not watched in normal mode, so an edge there is never qualified later.
- R8: A remote wake needs either bit of `bus_dom` to be held at 1 for DOM_TICKS consecutive clocks while the sampled pair is not 11. Counting starts only after normal mode is left. It sets the wake-up flag and `inh_o`. A shorter dominant phase does nothing.
- R9: `inh_o` rises only on one of four events:
  - a `bat_por` pulse,
  - a qualified local wake,
  - a qualified remote wake,
  - the effective standby select going from 0 to 1.
- R10: While `vcc_low` is 1, both control inputs count as 0. A standby select raised during undervoltage does not re-assert `inh_o` until the supply returns.
- R11: A wake or power-on event can land in the same clock as goto-sleep acceptance. When it does, the event wins: `inh_o` stays high and the request is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous reset, active low (power-on) |
| stb_pin | input | 1 | Standby select control pin |
| en_pin | input | 1 | Enable control pin |
| wake_pin | input | 1 | Local wake pin, idles high |
| bus_dom | input | 2 | Digitised dominant flag per bus wire |
| bat_por | input | 1 | One-clock battery power-on pulse |
| vcc_low | input | 1 | Supply below its standby threshold |
| rx_bit | input | 1 | Received bus data for normal mode |
| wire_fault | input | 1 | Wiring-fault flag from the failure manager |
| mode_o | output | 3 | Current mode code (see R1) |
| inh_o | output | 1 | Inhibit output; 1 = driven high, 0 = released |
| rxd_o | output | 1 | Value for the receive-data pin |
| err_o | output | 1 | Value for the error pin |

## Verification
A goto-sleep acceptance and a local wake qualification can both land in the same clock. One would release the inhibit output and the other would re-assert it. The bench provokes this by starting the wake edge exactly SLEEP_TICKS - WAKE_TICKS clocks after presenting 01, so that both filters complete on one edge. It judges the result by seeing `inh_o` still high and a later 00 decoding as standby with the wake-up flag visible on `rxd_o`. A second overlap covers a remote dominant phase that begins in normal mode and continues after leaving it. The bench checks that counting restarts only once normal mode has ended.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        MD_SLEEP   = 3'd0,
        MD_STANDBY = 3'd1,
        MD_GOTO    = 3'd2,
        MD_PWRSTBY = 3'd3,
        MD_NORMAL  = 3'd4
    } lpm_mode_e;

    // sampled {standby select, enable}
    localparam logic [1:0] CTL_NORMAL  = 2'b11;
    localparam logic [1:0] CTL_PWRSTBY = 2'b10;
    localparam logic [1:0] CTL_GOTO    = 2'b01;
    localparam logic [1:0] CTL_LOW     = 2'b00;

endpackage

// File: rtl/lpm_qual.sv
// Wake qualifier. EDGE_ARM=1: an edge then a stable level for TICKS clocks.
// EDGE_ARM=0: input held high for TICKS clocks. TICKS must be at least 2.
module lpm_qual #(
    parameter int TICKS    = 4,
    parameter bit EDGE_ARM = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sig,
    output logic hit
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LIM = CW'(TICKS);

    typedef struct packed {
        logic          prev;
        logic          run;
        logic [CW-1:0] cnt;
        logic          hit;
    } qst_t;

    qst_t s_d, s_q;

    generate
        if (EDGE_ARM) begin : g_edge
            always_comb begin
                s_d      = s_q;
                s_d.hit  = 1'b0;
                s_d.prev = sig;
                if (!en) begin
                    s_d.run = 1'b0;
                    s_d.cnt = '0;
                end else if (sig != s_q.prev) begin
                    s_d.run = 1'b1;
                    s_d.cnt = CW'(1);
                end else if (s_q.run) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    if (s_d.cnt == LIM) begin
                        s_d.hit = 1'b1;
                        s_d.run = 1'b0;
                    end
                end
            end
        end else begin : g_level
            always_comb begin
                s_d      = s_q;
                s_d.hit  = 1'b0;
                s_d.prev = sig;
                s_d.run  = 1'b0;
                if (en && sig) begin
                    if (s_q.cnt != LIM) s_d.cnt = s_q.cnt + 1'b1;
                    s_d.hit = (s_q.cnt == LIM - 1'b1);
                end else begin
                    s_d.cnt = '0;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{prev: 1'b1, run: 1'b0, cnt: '0, hit: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign hit = s_q.hit;

    AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.hit |=> !s_q.hit);                                   // R7
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !s_q.hit);                                       // R8

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int SLEEP_TICKS = 50,
    parameter int WAKE_TICKS  = 38,
    parameter int DOM_TICKS   = 38,
    parameter int N_WIRES     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stb_pin,
    input  logic               en_pin,
    input  logic               wake_pin,
    input  logic [N_WIRES-1:0] bus_dom,
    input  logic               bat_por,
    input  logic               vcc_low,
    input  logic               rx_bit,
    input  logic               wire_fault,
    output logic [2:0]         mode_o,
    output logic               inh_o,
    output logic               rxd_o,
    output logic               err_o
);
    localparam int GW = $clog2(SLEEP_TICKS + 1);
    localparam logic [GW-1:0] GLIM = GW'(SLEEP_TICKS);

    typedef struct packed {
        logic [1:0]    ctrl;
        logic [GW-1:0] gcnt;
        logic          armed;
        logic          inh;
        logic          wake_flag;
        logic          por_flag;
    } cst_t;

    cst_t s_d, s_q;

    logic               loc_hit;
    logic               rem_hit;
    logic [N_WIRES-1:0] rem_hits;
    logic               is_norm;
    logic [1:0]         ctl_now;
    logic               accept;
    logic               stb_rise;
    logic               inh_set;
    lpm_mode_e          mode;

    assign is_norm = (s_q.ctrl == CTL_NORMAL);

    lpm_qual #(.TICKS(WAKE_TICKS), .EDGE_ARM(1'b1)) u_loc (
        .clk(clk), .rst_n(rst_n), .en(!is_norm), .sig(wake_pin), .hit(loc_hit)
    );

    generate
        for (genvar w = 0; w < N_WIRES; w++) begin : g_wire
            lpm_qual #(.TICKS(DOM_TICKS), .EDGE_ARM(1'b0)) u_rem (
                .clk(clk), .rst_n(rst_n), .en(!is_norm), .sig(bus_dom[w]), .hit(rem_hits[w])
            );
        end
    endgenerate

    assign rem_hit = |rem_hits;

    always_comb begin
        ctl_now  = {stb_pin & ~vcc_low, en_pin & ~vcc_low};
        s_d      = s_q;
        s_d.ctrl = ctl_now;
        accept   = 1'b0;
        if (s_q.ctrl == CTL_GOTO) begin
            if (s_q.gcnt != GLIM) s_d.gcnt = s_q.gcnt + 1'b1;
            accept = (s_q.gcnt == GLIM - 1'b1);
        end else begin
            s_d.gcnt = '0;
        end
        stb_rise = ctl_now[1] & ~s_q.ctrl[1];
        inh_set  = bat_por | loc_hit | rem_hit | stb_rise;
        if (accept) begin
            s_d.armed = 1'b1;
            s_d.inh   = 1'b0;
        end
        if (s_q.ctrl[1]) s_d.armed = 1'b0;
        if (inh_set) begin
            s_d.inh   = 1'b1;
            s_d.armed = 1'b0;
        end
        if (loc_hit || rem_hit) s_d.wake_flag = 1'b1;
        if (bat_por)            s_d.por_flag  = 1'b1;
        if (is_norm) begin
            s_d.wake_flag = 1'b0;
            s_d.por_flag  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ctrl: CTL_LOW, gcnt: '0, armed: 1'b0, inh: 1'b1,
                     wake_flag: 1'b0, por_flag: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (s_q.ctrl)
            CTL_NORMAL:  mode = MD_NORMAL;
            CTL_PWRSTBY: mode = MD_PWRSTBY;
            CTL_GOTO:    mode = MD_GOTO;
            default:     mode = s_q.armed ? MD_SLEEP : MD_STANDBY;
        endcase
        if (is_norm) begin
            rxd_o = rx_bit;
            err_o = ~wire_fault;
        end else begin
            rxd_o = ~s_q.wake_flag;
            err_o = (s_q.ctrl == CTL_PWRSTBY) ? ~s_q.por_flag : ~s_q.wake_flag;
        end
    end

    assign mode_o = mode;
    assign inh_o  = s_q.inh;

    AST_NORMAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl == CTL_NORMAL) |=> (!s_q.wake_flag && !s_q.por_flag));      // R6
    AST_INH_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.inh) |-> ($past(bat_por) || $past(loc_hit) || $past(rem_hit)
                            || (s_q.ctrl[1] && !$past(s_q.ctrl[1]))));         // R9
    AST_INH_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.inh) |-> ($past(s_q.ctrl) == CTL_GOTO && s_q.armed));        // R2
    AST_SLEEP_NO_INH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_SLEEP) |-> !s_q.inh);                                      // R3
    AST_VCC_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_low |=> (s_q.ctrl == CTL_LOW));                                    // R10

endmodule

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;
    localparam int ST = 6;
    localparam int WT = 5;
    localparam int DT = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       stb_pin, en_pin, wake_pin, bat_por, vcc_low, rx_bit, wire_fault;
    logic [1:0] bus_dom;
    logic [2:0] mode_o;
    logic       inh_o, rxd_o, err_o;
    int         total = 0;
    int         bad   = 0;

    always #10 clk = ~clk;

    lpm_ctrl #(.SLEEP_TICKS(ST), .WAKE_TICKS(WT), .DOM_TICKS(DT)) u_lpm_ctrl (
        .clk(clk), .rst_n(rst_n), .stb_pin(stb_pin), .en_pin(en_pin),
        .wake_pin(wake_pin), .bus_dom(bus_dom), .bat_por(bat_por),
        .vcc_low(vcc_low), .rx_bit(rx_bit), .wire_fault(wire_fault),
        .mode_o(mode_o), .inh_o(inh_o), .rxd_o(rxd_o), .err_o(err_o)
    );

    // {stb, en, rx, fault, mode[2:0], rxd, err, inh}
    localparam logic [9:0] VEC [7] = '{
        {4'b1100, 3'd4, 3'b011},
        {4'b1111, 3'd4, 3'b101},
        {4'b1110, 3'd4, 3'b111},
        {4'b1010, 3'd3, 3'b111},
        {4'b0010, 3'd1, 3'b111},
        {4'b0110, 3'd2, 3'b111},
        {4'b0010, 3'd1, 3'b111}
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pins(input logic s, input logic e);
        stb_pin = s;
        en_pin  = e;
    endtask

    task automatic go_sleep;
        pins(1, 1); step(2);
        pins(0, 1); step(ST + 2);
        pins(0, 0); step(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; stb_pin = 0; en_pin = 0; wake_pin = 1; bus_dom = 2'b00;
        bat_por = 0; vcc_low = 0; rx_bit = 1; wire_fault = 0;
        step(2);
        rst_n = 1;
        step(1);
        // R4 reset state
        chk("R4 reset mode", mode_o, 1);
        chk("R4 reset inh", inh_o, 1);
        chk("R4 reset rxd", rxd_o, 1);
        chk("R4 reset err", err_o, 1);
        pins(1, 0); step(2);
        chk("R4 por flag on err", err_o, 0);
        chk("R1 power-on standby", mode_o, 3);
        pins(1, 1); step(2);

        // R1 R5 R6 vector table
        foreach (VEC[i]) begin
            {stb_pin, en_pin, rx_bit, wire_fault} = VEC[i][9:6];
            step(3);
            chk($sformatf("R1 vec%0d mode", i), mode_o, VEC[i][5:3]);
            chk($sformatf("R5 vec%0d rxd", i), rxd_o, VEC[i][2]);
            chk($sformatf("R5_R6 vec%0d err", i), err_o, VEC[i][1]);
            chk($sformatf("R2 vec%0d inh", i), inh_o, VEC[i][0]);
        end
        rx_bit = 1; wire_fault = 0;

        // R2 goto-sleep boundary
        pins(0, 1); step(ST);
        chk("R2 inh before accept", inh_o, 1);
        step(1);
        chk("R2 inh after accept", inh_o, 0);
        chk("R1 goto mode", mode_o, 2);
        pins(0, 0); step(2);
        chk("R3 sleep mode", mode_o, 0);
        chk("R5 sleep rxd", rxd_o, 1);

        // R7 local wake boundary
        wake_pin = 0; step(WT);
        chk("R7 no wake yet", rxd_o, 1);
        step(1);
        chk("R7 wake rxd", rxd_o, 0);
        chk("R7 wake err", err_o, 0);
        chk("R9 wake inh", inh_o, 1);
        chk("R3 back to standby", mode_o, 1);

        // R7 edge in normal is ignored
        pins(1, 1); step(2);
        wake_pin = 1; step(1);
        pins(1, 0); step(8);
        chk("R7 edge in normal ignored", rxd_o, 1);

        // R8 dominant starting in normal
        pins(1, 1); step(2);
        bus_dom = 2'b01; step(6);
        pins(1, 0); step(2);
        chk("R8 no early remote wake", rxd_o, 1);
        step(5);
        chk("R8 remote wake after leaving normal", rxd_o, 0);
        bus_dom = 2'b00;

        // R8 short dominant, then full
        go_sleep();
        chk("R3 sleep again", mode_o, 0);
        bus_dom = 2'b10; step(DT - 1);
        bus_dom = 2'b00; step(3);
        chk("R8 short dominant inh", inh_o, 0);
        chk("R8 short dominant rxd", rxd_o, 1);
        bus_dom = 2'b10; step(DT);
        chk("R8 boundary rxd", rxd_o, 1);
        step(1);
        chk("R8 remote wake rxd", rxd_o, 0);
        chk("R9 remote wake inh", inh_o, 1);
        bus_dom = 2'b00;

        // R10 undervoltage
        pins(1, 1); step(2);
        vcc_low = 1; step(1);
        chk("R10 forced standby", mode_o, 1);
        vcc_low = 0;
        go_sleep();
        vcc_low = 1; pins(1, 0); step(3);
        chk("R10 stays sleep", mode_o, 0);
        chk("R10 no inh under low supply", inh_o, 0);
        vcc_low = 0; step(1);
        chk("R9 stb rise inh", inh_o, 1);
        chk("R1 power-on standby again", mode_o, 3);

        // R4 battery power-on pulse
        go_sleep();
        bat_por = 1; step(1); bat_por = 0;
        chk("R4 por pulse inh", inh_o, 1);
        chk("R3 por leaves sleep", mode_o, 1);
        pins(1, 0); step(2);
        chk("R4 por flag after pulse", err_o, 0);
        pins(1, 1); step(2);

        // R11 accept and wake in the same cycle
        pins(0, 1); step(1);
        wake_pin = 0; step(ST);
        chk("R11 inh kept high", inh_o, 1);
        pins(0, 0); step(2);
        chk("R11 standby not sleep", mode_o, 1);
        chk("R11 wake visible", rxd_o, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule